// File: doc/BRIEF.md
# Board Error and Diagnostic Register Bank

This block is a small bank of memory-mapped registers for a processor board. It holds four 32-bit words: a boot and diagnostic word, a memory-system error word, and two words that capture the local-memory address of a CPU-side error and of a DMA-side error. Software picks a word by its longword offset from a base address. Every word has its own masks for what reads back, what software may write and what software clears by writing ones.

Pulses from the memory and bus logic set sticky error flags. When a flag goes from clear to set, the block also captures the address that came with the event. If an event arrives while its flag is already set, the block raises a lost-error flag instead. A configuration input decides the boot code that loads at reset. An output shows the break-enable bit of the boot word.

Top module: `board_diag_regs`

## Requirements
- R1: The selected word is (reg_addr - BASE) >> 2, so address bits 1:0 are ignored. Index 0 is the boot word, 1 is the error word, 2 is the CPU error address and 3 is the DMA error address. Every other index reads 0, and writes to it have no effect.
- R2: On reset the boot word reads 0x0000C00F when full_diag is 1 and 0x0000C30F when it is 0. The fields are power-OK at bit 15, break enable at bit 14, CPU code at bits 12:11 (reset 0), boot code at bits 9:8 (0 or 3) and display at bits 3:0 (reset 0xF).
- R3: A write to the boot word changes only bits 3:0. All its other bits keep their values.
- R4: brk_en always equals bit 14 of the boot word.
- R5: In the error word, bits 1:0 are read-write. Bits 9:8 show mem_code. Bit 2 and bits 31:10 read 0.
- R6: Error-word bits 7:3 clear when a 1 is written to them. Writing 0 to any of them leaves it unchanged.
- R7: Each event pulse sets its flag on the next clock edge. The flags are: ev_dma_par sets bit 4, ev_cpu_par sets bit 5, ev_mem_par sets bit 6 and ev_mchk sets bit 7. A set in the same cycle as a write-one-to-clear of that bit wins.
- R8: ev_mchk does not set bit 7 when bit 5 or bit 6 was already set before that edge.
- R9: Bit 3 (lost error) sets when an event arrives whose flag is already set. For ev_mchk this applies only when the event is not suppressed.
- R10: When ev_dma_par sets bit 4 from clear, the DMA word captures dma_err_addr. When a CPU-side event (bit 5, 6, or an unsuppressed bit 7) sets its flag from clear, the CPU word captures cpu_err_addr. Otherwise both words hold their values.
- R11: The two error-address words read back only bits 14:0 and ignore all writes.
- R12: Reset clears the error word's stored bits and both error-address words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| full_diag | input | 1 | Selects the full-diagnostic boot code at reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| mem_code | input | 2 | Memory code shown in error-word bits 9:8 |
| ev_dma_par | input | 1 | DMA bus parity error pulse |
| ev_cpu_par | input | 1 | CPU bus parity error pulse |
| ev_mem_par | input | 1 | CPU memory parity error pulse |
| ev_mchk | input | 1 | Memory-reference machine-check pulse |
| cpu_err_addr | input | EADDR_W | Address that goes with CPU-side events |
| dma_err_addr | input | EADDR_W | Address that goes with DMA parity events |
| brk_en | output | 1 | Break enable from the boot word |

## Verification
The bench targets same-cycle conflicts: an event arriving in the same cycle as a write-one-to-clear of its own bit. A design that lets the clear win loses the error. It repeats events whose flag is already set; a wrong design overwrites the first captured address or misses the lost-error flag. It raises machine checks with and without a parity flag pending. A design that ignores the suppression sets non-existent-memory behind a parity error and moves the CPU address word. It also probes odd byte addresses and addresses below and above the window, where a decode error would alias another word or let a write land.

// File: rtl/brd_regs_pkg.sv
// Package: shared indices, field positions and masks for the board
// register bank. Assumes 32-bit words on a longword-indexed window.
package brd_regs_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned IDX_BOOT  = 0;
    localparam int unsigned IDX_MERR  = 1;
    localparam int unsigned IDX_CADDR = 2;
    localparam int unsigned IDX_DADDR = 3;

    // error-word flag positions (write-one-to-clear region is 7:3)
    localparam int unsigned B_LOST = 3;
    localparam int unsigned B_DPAR = 4;
    localparam int unsigned B_CPAR = 5;
    localparam int unsigned B_MPAR = 6;
    localparam int unsigned B_NXM  = 7;
    localparam int unsigned FLAG_N = 5;

    localparam logic [1:0] BOOT_FULL = 2'd0;
    localparam logic [1:0] BOOT_SKIP = 2'd3;
    localparam logic [1:0] CPU_ARB   = 2'd0;

    // one-cycle event pulses from memory and bus logic
    typedef struct packed {
        logic dpar;
        logic cpar;
        logic mpar;
        logic mchk;
    } err_ev_t;
endpackage

// File: rtl/brd_boot_reg.sv
// Boot/diagnostic word. Only the 4-bit display field is writable; the
// boot code is chosen from full_diag at reset, the other fields are fixed
// reset constants. Assumes a synchronous active-low reset.
module brd_boot_reg
    import brd_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_diag,
    input  logic              wr_sel,
    input  logic [3:0]        wr_disp,
    output logic [WORD_W-1:0] rd_word,
    output logic              brk_en
);
    logic [3:0] disp_q;
    logic [1:0] boot_q;
    logic [1:0] cpu_q;
    logic       brk_q;
    logic       pok_q;

    // Load reset constants; accept display writes afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_q <= 4'hF;
            boot_q <= full_diag ? BOOT_FULL : BOOT_SKIP;
            cpu_q  <= CPU_ARB;
            brk_q  <= 1'b1;
            pok_q  <= 1'b1;
        end else if (wr_sel) begin
            disp_q <= wr_disp;
        end
    end

    // Assemble the visible word; unlisted bits read zero.
    always_comb begin
        rd_word        = '0;
        rd_word[3:0]   = disp_q;
        rd_word[9:8]   = boot_q;
        rd_word[12:11] = cpu_q;
        rd_word[14]    = brk_q;
        rd_word[15]    = pok_q;
    end

    assign brk_en = brk_q;

    // R3
    fixed_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> $stable(boot_q) && $stable(cpu_q) && $stable(brk_q) && $stable(pok_q));
    // R3
    disp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> disp_q == $past(wr_disp));
endmodule

// File: rtl/brd_mem_err_reg.sv
// Memory-system error word. Holds two read-write control bits and five
// sticky flags cleared by writing ones. Events beat clears in the same
// cycle. Produces capture strobes for the error-address words when a
// flag rises from clear. Assumes events are one-cycle pulses.
module brd_mem_err_reg
    import brd_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        mem_code,
    input  err_ev_t           ev,
    output logic [WORD_W-1:0] rd_word,
    output logic              cpu_cap,
    output logic              dma_cap
);
    logic [1:0]        ctl_q;
    logic [FLAG_N-1:0] flag_q;   // bit i holds error-word bit B_LOST+i
    logic [FLAG_N-1:0] flag_set;
    logic [FLAG_N-1:0] flag_clr;
    logic              nxm_eff;
    logic              lost_ev;

    localparam int unsigned F_LOST = B_LOST - B_LOST;
    localparam int unsigned F_DPAR = B_DPAR - B_LOST;
    localparam int unsigned F_CPAR = B_CPAR - B_LOST;
    localparam int unsigned F_MPAR = B_MPAR - B_LOST;
    localparam int unsigned F_NXM  = B_NXM  - B_LOST;

    // Work out which flags rise this cycle and whether one is lost.
    always_comb begin
        nxm_eff  = ev.mchk & ~flag_q[F_CPAR] & ~flag_q[F_MPAR];
        lost_ev  = (ev.dpar & flag_q[F_DPAR]) | (ev.cpar & flag_q[F_CPAR]) |
                   (ev.mpar & flag_q[F_MPAR]) | (nxm_eff & flag_q[F_NXM]);
        flag_set = '0;
        flag_set[F_LOST] = lost_ev;
        flag_set[F_DPAR] = ev.dpar;
        flag_set[F_CPAR] = ev.cpar;
        flag_set[F_MPAR] = ev.mpar;
        flag_set[F_NXM]  = nxm_eff;
        flag_clr = wr_sel ? wr_data[B_NXM:B_LOST] : '0;
    end

    // Capture strobes fire only on a clear-to-set transition.
    always_comb begin
        dma_cap = ev.dpar & ~flag_q[F_DPAR];
        cpu_cap = (ev.cpar & ~flag_q[F_CPAR]) | (ev.mpar & ~flag_q[F_MPAR]) |
                  (nxm_eff & ~flag_q[F_NXM]);
    end

    // Control bits take write data directly.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (wr_sel) ctl_q <= wr_data[1:0];
    end

    // One sticky cell per flag: set wins over clear.
    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)           flag_q[i] <= 1'b0;
            else if (flag_set[i]) flag_q[i] <= 1'b1;
            else if (flag_clr[i]) flag_q[i] <= 1'b0;
        end
    end

    // Readable set: bits 9:3 and 1:0.
    always_comb begin
        rd_word                = '0;
        rd_word[1:0]           = ctl_q;
        rd_word[B_NXM:B_LOST]  = flag_q;
        rd_word[9:8]           = mem_code;
    end

    // R8
    nxm_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev.mchk && (flag_q[F_CPAR] || flag_q[F_MPAR]) && !flag_q[F_NXM] |=> !flag_q[F_NXM]);
    // R6
    w1c_dpar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel && wr_data[B_DPAR] && !ev.dpar |=> !flag_q[F_DPAR]);
    // R6
    w0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel && !wr_data[B_MPAR] && flag_q[F_MPAR] |=> flag_q[F_MPAR]);
    // R7
    set_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev.mpar |=> flag_q[F_MPAR]);
    // R9
    lost_dpar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev.dpar && flag_q[F_DPAR] |=> flag_q[F_LOST]);
endmodule

// File: rtl/brd_err_addr_reg.sv
// Error-address word. Loads the incoming address on a capture strobe and
// otherwise holds; software writes never reach it.
module brd_err_addr_reg #(
    parameter int unsigned EADDR_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap,
    input  logic [EADDR_W-1:0] addr_in,
    output logic [EADDR_W-1:0] addr_q
);
    // Capture on strobe, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   addr_q <= '0;
        else if (cap) addr_q <= addr_in;
    end

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(addr_q));
    // R10
    addr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> addr_q == $past(addr_in));
endmodule

// File: rtl/board_diag_regs.sv
// Top of the board register bank: decodes the longword index from the
// byte address, steers writes, and muxes read data. Indices outside 0..3
// read zero and drop writes. Read data is combinational on reg_addr.
module board_diag_regs
    import brd_regs_pkg::*;
#(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned EADDR_W = 15,
    parameter logic [ADDR_W-1:0] BASE = 16'h0040
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               full_diag,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [1:0]         mem_code,
    input  logic               ev_dma_par,
    input  logic               ev_cpu_par,
    input  logic               ev_mem_par,
    input  logic               ev_mchk,
    input  logic [EADDR_W-1:0] cpu_err_addr,
    input  logic [EADDR_W-1:0] dma_err_addr,
    output logic               brk_en
);
    localparam int unsigned NUM_ADDR = 2;
    localparam int unsigned IDX_W    = ADDR_W - 2;

    logic [ADDR_W-1:0]  offs;
    logic [IDX_W-1:0]   idx;
    logic               sel_boot, sel_merr;
    logic [WORD_W-1:0]  boot_word, merr_word, wdata32;
    logic               cpu_cap, dma_cap;
    err_ev_t            ev;
    logic [NUM_ADDR-1:0]               cap_v;
    logic [NUM_ADDR-1:0][EADDR_W-1:0]  ain_v;
    logic [NUM_ADDR-1:0][EADDR_W-1:0]  aq_v;

    // Longword index decode.
    always_comb begin
        offs     = reg_addr - BASE;
        idx      = offs[ADDR_W-1:2];
        sel_boot = reg_wr && (idx == IDX_W'(IDX_BOOT));
        sel_merr = reg_wr && (idx == IDX_W'(IDX_MERR));
        wdata32  = WORD_W'(reg_wdata);
        ev       = '{dpar: ev_dma_par, cpar: ev_cpu_par, mpar: ev_mem_par, mchk: ev_mchk};
    end

    brd_boot_reg u_boot (
        .clk       (clk),
        .rst_n     (rst_n),
        .full_diag (full_diag),
        .wr_sel    (sel_boot),
        .wr_disp   (wdata32[3:0]),
        .rd_word   (boot_word),
        .brk_en    (brk_en)
    );

    brd_mem_err_reg u_merr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (sel_merr),
        .wr_data  (wdata32),
        .mem_code (mem_code),
        .ev       (ev),
        .rd_word  (merr_word),
        .cpu_cap  (cpu_cap),
        .dma_cap  (dma_cap)
    );

    // Slot 0 is the CPU-side word, slot 1 the DMA-side word.
    always_comb begin
        cap_v[0] = cpu_cap;
        cap_v[1] = dma_cap;
        ain_v[0] = cpu_err_addr;
        ain_v[1] = dma_err_addr;
    end

    for (genvar k = 0; k < NUM_ADDR; k++) begin : g_addr
        brd_err_addr_reg #(.EADDR_W(EADDR_W)) u_ea (
            .clk     (clk),
            .rst_n   (rst_n),
            .cap     (cap_v[k]),
            .addr_in (ain_v[k]),
            .addr_q  (aq_v[k])
        );
    end

    // Read mux; unknown indices return zero.
    always_comb begin
        reg_rdata = '0;
        if (idx == IDX_W'(IDX_BOOT))       reg_rdata = DATA_W'(boot_word);
        else if (idx == IDX_W'(IDX_MERR))  reg_rdata = DATA_W'(merr_word);
        else if (idx == IDX_W'(IDX_CADDR)) reg_rdata = DATA_W'(aq_v[0]);
        else if (idx == IDX_W'(IDX_DADDR)) reg_rdata = DATA_W'(aq_v[1]);
    end

    // R11
    caddr_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !cpu_cap |=> $stable(aq_v[0]));
    // R4
    brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> $stable(brk_en));
endmodule

// File: tb/board_diag_regs_tb.sv
module board_diag_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        full_diag = 1'b0;
    logic [15:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  mem_code = 2'b10;
    logic        ev_dma_par = 0, ev_cpu_par = 0, ev_mem_par = 0, ev_mchk = 0;
    logic [14:0] cpu_err_addr = '0, dma_err_addr = '0;
    logic        brk_en;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    localparam logic [15:0] A_BOOT = 16'h0040, A_MERR = 16'h0044,
                            A_CADR = 16'h0048, A_DADR = 16'h004C;

    always #10 clk = ~clk;

    board_diag_regs dut_i (
        .clk(clk), .rst_n(rst_n), .full_diag(full_diag), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_code(mem_code), .ev_dma_par(ev_dma_par), .ev_cpu_par(ev_cpu_par),
        .ev_mem_par(ev_mem_par), .ev_mchk(ev_mchk), .cpu_err_addr(cpu_err_addr),
        .dma_err_addr(dma_err_addr), .brk_en(brk_en)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd_chk(string req, logic [15:0] a, logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #2;
        check(req, reg_rdata, exp);
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // pulse events (dpar,cpar,mpar,mchk) for one cycle, optional write alongside
    task automatic pulse(logic [3:0] evs, logic [14:0] ca, logic [14:0] da,
                         logic do_wr, logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        {ev_dma_par, ev_cpu_par, ev_mem_par, ev_mchk} = evs;
        cpu_err_addr = ca; dma_err_addr = da;
        reg_wr = do_wr; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        {ev_dma_par, ev_cpu_par, ev_mem_par, ev_mchk} = '0;
        reg_wr = 1'b0;
    endtask

    task automatic do_reset(logic fd);
        @(negedge clk);
        rst_n = 1'b0; full_diag = fd;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset;
        do_reset(1'b0);
        rd_chk("R2", A_BOOT, 32'h0000C30F);
        check("R4", {31'd0, brk_en}, 32'd1);
        rd_chk("R12", A_MERR, 32'h00000200);
        rd_chk("R12", A_CADR, 32'h0);
        rd_chk("R12", A_DADR, 32'h0);
        do_reset(1'b1);
        rd_chk("R2", A_BOOT, 32'h0000C00F);
    endtask

    task automatic t_boot_write;
        wr(A_BOOT, 32'hFFFF_FFF0);
        rd_chk("R3", A_BOOT, 32'h0000C000);
        wr(A_BOOT, 32'h0000_0005);
        rd_chk("R3", A_BOOT, 32'h0000C005);
        check("R4", {31'd0, brk_en}, 32'd1);
    endtask

    task automatic t_decode;
        rd_chk("R1", 16'h0041, 32'h0000C005);
        rd_chk("R1", 16'h0050, 32'h0);
        rd_chk("R1", 16'h003C, 32'h0);
        wr(16'h0050, 32'h0000_000A);
        wr(16'h003C, 32'h0000_000A);
        rd_chk("R1", A_BOOT, 32'h0000C005);
    endtask

    task automatic t_ctl_bits;
        wr(A_MERR, 32'hFFFF_FFFF);
        rd_chk("R5", A_MERR, 32'h00000203);
        wr(A_MERR, 32'h0);
        rd_chk("R5", A_MERR, 32'h00000200);
    endtask

    task automatic t_dma_events;
        pulse(4'b1000, 15'h0, 15'h1234, 0, A_MERR, 0);
        rd_chk("R7", A_MERR, 32'h00000210);
        rd_chk("R10", A_DADR, 32'h00001234);
        pulse(4'b1000, 15'h0, 15'h7777, 0, A_MERR, 0);
        rd_chk("R9", A_MERR, 32'h00000218);
        rd_chk("R10", A_DADR, 32'h00001234);
        wr(A_MERR, 32'h0);
        rd_chk("R6", A_MERR, 32'h00000218);
        wr(A_MERR, 32'h08);
        rd_chk("R6", A_MERR, 32'h00000210);
        wr(A_MERR, 32'h10);
        rd_chk("R6", A_MERR, 32'h00000200);
    endtask

    task automatic t_nxm;
        pulse(4'b0100, 15'h0ABC, 15'h0, 0, A_MERR, 0);
        rd_chk("R7", A_MERR, 32'h00000220);
        rd_chk("R10", A_CADR, 32'h00000ABC);
        pulse(4'b0001, 15'h0111, 15'h0, 0, A_MERR, 0);
        rd_chk("R8", A_MERR, 32'h00000220);
        rd_chk("R8", A_CADR, 32'h00000ABC);
        wr(A_MERR, 32'h20);
        pulse(4'b0001, 15'h0222, 15'h0, 0, A_MERR, 0);
        rd_chk("R8", A_MERR, 32'h00000280);
        rd_chk("R10", A_CADR, 32'h00000222);
        pulse(4'b0001, 15'h0333, 15'h0, 0, A_MERR, 0);
        rd_chk("R9", A_MERR, 32'h00000288);
        rd_chk("R10", A_CADR, 32'h00000222);
    endtask

    task automatic t_priority;
        pulse(4'b0010, 15'h0444, 15'h0, 1, A_MERR, 32'h0000_00F8);
        rd_chk("R7", A_MERR, 32'h00000240);
        rd_chk("R10", A_CADR, 32'h00000444);
        wr(A_CADR, 32'hFFFF_FFFF);
        wr(A_DADR, 32'h0000_0000);
        rd_chk("R11", A_CADR, 32'h00000444);
        rd_chk("R11", A_DADR, 32'h00001234);
        mem_code = 2'b01;
        rd_chk("R5", A_MERR, 32'h00000140);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_boot_write();
        t_decode();
        t_ctl_bits();
        t_dma_events();
        t_nxm();
        t_priority();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule